// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block sits beside a small 8-bit processor core and collects two interrupt sources into sticky flags. A falling edge on an active-low external interrupt pin is synchronised and captured in one flag. A one-cycle timer-overflow pulse is captured in another. Both flags live in an 8-bit status register. An 8-bit mask register gates what software sees when it reads the status register. The same mask gates which flags may raise a request to the core.

A global enable bit in a control register gates the request output. The core's instruction decoder drives strobes that enable interrupts, disable them and return from an interrupt handler. Its interrupt-accept strobe also clears the enable. Software reaches the three registers through a plain port with a select, a write strobe and write data. The read data is a combinational view of the registered state. Software can only clear flags. It can never set them.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags, the mask register and the global enable are 0, every register reads 0 and `irq_req` is 0.
- R2: A falling edge on `ext_irq_n` sets status bit 3. The pin passes through two synchroniser flops, so the flag reads 1 after the third rising clock edge that follows the pin change. A rising edge of the pin sets nothing.
- R3: A high `tmr_ovf` sampled at a clock edge sets status bit 0 at that edge.
- R4: A write to the status register (`reg_sel` = 0) clears each flag whose write-data bit is 0. A flag whose write-data bit is 1 keeps its value, so a 0 flag stays 0.
- R5: Reading the status register returns the flags ANDed bit by bit with the mask register. Bits 1, 2 and 4 to 7 always read 0. Select value 3 reads 0.
- R6: The mask register (`reg_sel` = 1) is written and read back in full as 8 bits.
- R7: The control register (`reg_sel` = 2) holds the global enable in bit 6, and a write sets that bit from `reg_wdata[6]`. All its other bits read 0.
- R8: `irq_ack` or `ins_disi` clears the global enable at the next edge. Either one takes priority over `ins_eni`, `ins_reti` and a control write made in the same cycle.
- R9: `ins_eni` or `ins_reti` sets the global enable at the next edge, unless R8 applies.
- R10: `irq_req` is 1 exactly when the global enable is 1 and at least one flag has its mask bit set.
- R11: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_n | input | 1 | Asynchronous external interrupt pin; it requests on a falling edge |
| tmr_ovf | input | 1 | Timer overflow pulse |
| reg_sel | input | 2 | Register select: 0 status, 1 mask, 2 control, 3 none |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_ack | input | 1 | Core accepted an interrupt |
| ins_eni | input | 1 | Enable-interrupt instruction strobe |
| ins_disi | input | 1 | Disable-interrupt instruction strobe |
| ins_reti | input | 1 | Return-from-interrupt instruction strobe |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The hardest case to reach is a hardware set that lands in the same cycle as a software clear of the same flag. For the external flag, the set edge lies three clocks behind the pin, which makes the collision awkward to line up. The stimulus therefore uses the timer flag. It raises `tmr_ovf` and writes zero to the status register on the same clock edge, then checks that the flag survives. A later plain write checks that the flag does clear. Priority among the enable strobes is tested the same way: an accept strobe and an enable strobe are driven together.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Flags after a software write: a 0 data bit clears, a 1 keeps; hardware sets win.
  function automatic logic [REG_W-1:0] flags_next(
    input logic [REG_W-1:0] cur,
    input logic             clr_en,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] set_vec
  );
    logic [REG_W-1:0] kept;
    kept = clr_en ? (cur & wdata) : cur;
    return kept | set_vec;
  endfunction

  function automatic logic [REG_W-1:0] status_view(
    input logic [REG_W-1:0] flags,
    input logic [REG_W-1:0] mask
  );
    return flags & mask;
  endfunction

  function automatic logic request_of(
    input logic             enable,
    input logic [REG_W-1:0] flags,
    input logic [REG_W-1:0] mask
  );
    return enable & (|(flags & mask));
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  localparam int LAST = STAGES;

  // chain[0..STAGES-1] synchronise; chain[STAGES] holds the previous synced value
  logic [LAST:0] chain;

  generate
    for (genvar i = 0; i <= LAST; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign fall = chain[LAST] & ~chain[LAST-1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int EXT_BIT = 3,
  parameter int TMR_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_set,
  input  logic             tmr_set,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_data,
  output logic [REG_W-1:0] flags
);
  localparam logic [REG_W-1:0] EXT_ONE = REG_W'(1) << EXT_BIT;
  localparam logic [REG_W-1:0] TMR_ONE = REG_W'(1) << TMR_BIT;

  logic [REG_W-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (ext_set) set_vec = set_vec | EXT_ONE;
    if (tmr_set) set_vec = set_vec | TMR_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_next(flags, clr_en, clr_data, set_vec);
  end
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irq_flag_pkg::*;
#(
  parameter int GIE_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             disi,
  input  logic             eni,
  input  logic             reti,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic             gie
);
  logic kill, arm;

  assign kill = ack | disi;
  assign arm  = eni | reti;

  always_ff @(posedge clk) begin
    if (!rst_n)     gie <= 1'b0;
    else if (kill)  gie <= 1'b0;
    else if (arm)   gie <= 1'b1;
    else if (wr_en) gie <= wdata[GIE_BIT];
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int EXT_BIT     = 3,
  parameter int TMR_BIT     = 0,
  parameter int GIE_BIT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_irq_n,
  input  logic             tmr_ovf,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             irq_ack,
  input  logic             ins_eni,
  input  logic             ins_disi,
  input  logic             ins_reti,
  output logic             irq_req
);
  localparam logic [REG_W-1:0] GIE_ONE = REG_W'(1) << GIE_BIT;

  // Named internal events for the checker
  logic             ext_fall;
  logic [REG_W-1:0] flag_q;
  logic [REG_W-1:0] mask_q;
  logic             gie_q;
  logic             wr_status, wr_mask, wr_ctrl;

  assign wr_status = reg_wr && (reg_sel == SEL_STATUS);
  assign wr_mask   = reg_wr && (reg_sel == SEL_MASK);
  assign wr_ctrl   = reg_wr && (reg_sel == SEL_CTRL);

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (ext_irq_n),
    .fall  (ext_fall)
  );

  irq_flag_bank #(.EXT_BIT(EXT_BIT), .TMR_BIT(TMR_BIT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_set  (ext_fall),
    .tmr_set  (tmr_ovf),
    .clr_en   (wr_status),
    .clr_data (reg_wdata),
    .flags    (flag_q)
  );

  irq_enable_ctrl #(.GIE_BIT(GIE_BIT)) u_gie (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (irq_ack),
    .disi  (ins_disi),
    .eni   (ins_eni),
    .reti  (ins_reti),
    .wr_en (wr_ctrl),
    .wdata (reg_wdata),
    .gie   (gie_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata;
  end

  always_comb begin
    unique case (reg_sel)
      SEL_STATUS: reg_rdata = status_view(flag_q, mask_q);
      SEL_MASK:   reg_rdata = mask_q;
      SEL_CTRL:   reg_rdata = gie_q ? GIE_ONE : '0;
      default:    reg_rdata = '0;
    endcase
  end

  assign irq_req = request_of(gie_q, flag_q, mask_q);
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int EXT_BIT = 3,
  parameter int TMR_BIT = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_ovf,
  input logic       ext_fall,
  input logic [1:0] reg_sel,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic [7:0] flag_q,
  input logic [7:0] mask_q,
  input logic       gie_q,
  input logic       irq_ack,
  input logic       ins_eni,
  input logic       ins_disi,
  input logic       ins_reti,
  input logic       irq_req
);
  localparam logic [7:0] USED = (8'd1 << EXT_BIT) | (8'd1 << TMR_BIT);

  assert_ext_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall |=> flag_q[EXT_BIT]);

  assert_tmr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> flag_q[TMR_BIT]);

  assert_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && !tmr_ovf && !ext_fall)
      |=> ((flag_q & ~$past(flag_q)) == 8'h00));

  assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> ((reg_rdata & ~USED) == 8'h00));

  assert_gie_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack || ins_disi) |=> !gie_q);

  assert_gie_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ins_eni || ins_reti) && !irq_ack && !ins_disi) |=> gie_q);

  assert_req_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie_q && ((flag_q & mask_q) != 8'h00)));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.EXT_BIT(EXT_BIT), .TMR_BIT(TMR_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tmr_ovf   (tmr_ovf),
  .ext_fall  (ext_fall),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .flag_q    (flag_q),
  .mask_q    (mask_q),
  .gie_q     (gie_q),
  .irq_ack   (irq_ack),
  .ins_eni   (ins_eni),
  .ins_disi  (ins_disi),
  .ins_reti  (ins_reti),
  .irq_req   (irq_req)
);

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_irq_n = 1'b1;
  logic       tmr_ovf = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_ack = 1'b0, ins_eni = 1'b0, ins_disi = 1'b0, ins_reti = 1'b0;
  logic       irq_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .tmr_ovf(tmr_ovf),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .ins_eni(ins_eni), .ins_disi(ins_disi), .ins_reti(ins_reti),
    .irq_req(irq_req)
  );

  // Bench model built from the requirements
  logic [7:0] m_flags = 8'h00;
  logic [7:0] m_mask  = 8'h00;
  logic       m_gie   = 1'b0;

  typedef struct {
    logic [1:0] sel;
    logic [7:0] exp_d;
    logic       exp_irq;
    string      tag;
  } item_t;

  item_t sb[$];

  function automatic logic [7:0] model_read(input logic [1:0] sel);
    case (sel)
      2'd0:    return m_flags & m_mask & 8'h09;
      2'd1:    return m_mask;
      2'd2:    return m_gie ? 8'h40 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  // Monitor: compares queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (reg_rdata !== it.exp_d || irq_req !== it.exp_irq) begin
          failures++;
          $display("FAIL %s sel=%0d rdata=%02h exp=%02h irq=%b exp_irq=%b",
                   it.tag, it.sel, reg_rdata, it.exp_d, irq_req, it.exp_irq);
        end
      end
    end
  end

  task automatic check(input logic [1:0] sel, input string tag);
    item_t it;
    reg_sel = sel;
    it.sel = sel;
    it.exp_d = model_read(sel);
    it.exp_irq = m_gie && ((m_flags & m_mask) != 8'h00);
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (sel)
      2'd0: m_flags = m_flags & d;
      2'd1: m_mask = d;
      2'd2: m_gie = d[6];
      default: ;
    endcase
  endtask

  task automatic pulse_tmr();
    tmr_ovf = 1'b1;
    @(negedge clk);
    tmr_ovf = 1'b0;
    m_flags[0] = 1'b1;
  endtask

  task automatic ext_fall_seq();
    ext_irq_n = 1'b0;
    repeat (3) @(negedge clk);
    m_flags[3] = 1'b1;
  endtask

  task automatic strobe(input int which);
    case (which)
      0: begin ins_eni  = 1'b1; m_gie = 1'b1; end
      1: begin ins_reti = 1'b1; m_gie = 1'b1; end
      2: begin ins_disi = 1'b1; m_gie = 1'b0; end
      default: begin irq_ack = 1'b1; m_gie = 1'b0; end
    endcase
    @(negedge clk);
    ins_eni = 1'b0; ins_reti = 1'b0; ins_disi = 1'b0; irq_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(2'd0, "R1 status after reset");
    check(2'd1, "R1 mask after reset");
    check(2'd2, "R1 control after reset");

    wr_reg(2'd1, 8'hFF);
    check(2'd1, "R6 mask readback FF");
    wr_reg(2'd0, 8'hFF);
    check(2'd0, "R4 write of ones sets no flag");

    pulse_tmr();
    check(2'd0, "R3 timer flag set, R10 no request while disabled");

    ext_fall_seq();
    check(2'd0, "R2 external flag after falling edge");
    wr_reg(2'd0, 8'hF7);
    check(2'd0, "R4 clear of bit 3 only");
    ext_irq_n = 1'b1;
    repeat (4) @(negedge clk);
    check(2'd0, "R2 rising edge sets nothing");
    ext_fall_seq();
    ext_irq_n = 1'b1;
    check(2'd0, "R2 second falling edge");

    wr_reg(2'd1, 8'h08);
    check(2'd0, "R5 status masked to bit 3");
    wr_reg(2'd1, 8'hF6);
    check(2'd0, "R5 mask without flag bits reads zero");
    wr_reg(2'd1, 8'h5A);
    check(2'd1, "R6 mask readback 5A");
    check(2'd3, "R5 select 3 reads zero");

    strobe(0);
    check(2'd2, "R9 enable instruction sets enable, R7 bit 6");
    wr_reg(2'd1, 8'h00);
    check(2'd0, "R10 no request with mask zero");
    wr_reg(2'd1, 8'h01);
    check(2'd0, "R10 request from timer flag");
    strobe(3);
    check(2'd2, "R8 accept clears enable");
    strobe(1);
    check(2'd2, "R9 return sets enable");
    strobe(2);
    check(2'd2, "R8 disable clears enable");
    wr_reg(2'd2, 8'hFF);
    check(2'd2, "R7 control write only bit 6 visible");
    wr_reg(2'd2, 8'h00);
    check(2'd2, "R7 control write clears enable");

    ins_eni = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    ins_eni = 1'b0; irq_ack = 1'b0; m_gie = 1'b0;
    check(2'd2, "R8 accept wins over enable");
    ins_reti = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h00; reg_wr = 1'b1; ins_disi = 1'b1;
    @(negedge clk);
    ins_reti = 1'b0; reg_wr = 1'b0; ins_disi = 1'b0; m_gie = 1'b0;
    check(2'd2, "R8 disable wins over return and write");

    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd0, 8'h00);
    check(2'd0, "R4 write zero clears all");
    tmr_ovf = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    tmr_ovf = 1'b0; reg_wr = 1'b0;
    m_flags = 8'h01;
    check(2'd0, "R11 set wins over same-cycle clear");
    strobe(0);
    check(2'd0, "R10 request with enable and flag");
    wr_reg(2'd0, 8'hFE);
    check(2'd0, "R4 later clear removes flag and request");

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule